// File: doc/BRIEF.md
# Write-Combining Posted Line Buffer

This block sits between a processor's 32-bit store path and a memory write port one cache line (256 bits) wide. Consecutive stores that land in the same line are gathered into one line image with a per-byte enable mask. The gathered line then leaves as a single masked wide write. Stores are posted: the processor sees its store finish as soon as the buffer takes it, well before memory is written. Long runs of sequential stores, such as a register-file spill, therefore cost one wide memory write per line instead of one per word.

Two line-sized stages hold the data. The gathering stage collects stores. The outgoing stage presents a finished line to memory and holds it until memory accepts it. A line moves from the gathering stage to the outgoing stage in any of these cases:
- a store arrives for some other line;
- every byte of the line has been written;
- the drain input is held;
- a read asks for that line.

A read whose line is still held in either stage is stalled until that line has reached memory. Memory therefore never returns data older than a posted store. The processor is assumed to present at most one of a read or a store in any cycle.

Top module: `wr_combine_buf`

## Requirements
- R1: While reset is asserted (`rst_n` low) and directly after it, `empty` is 1, `mem_wr_valid` is 0 and `wr_ready` is 1.
- R2: Let a store have word address `wr_addr`. Its line address is `wr_addr[ADDR_W-3:3]` and its word slot is `w = wr_addr[2:0]`. Enable bit `j` of `wr_be` controls byte `j` of `wr_data` (bits 8j+7:8j). That byte lands in line byte `4w+j`, which is `mem_wr_data` bits 8(4w+j)+7:8(4w+j), and is flagged by `mem_wr_be[4w+j]`. The line address appears on `mem_wr_addr`.
- R3: Stores to the same line merge into one memory write. The mask of that write is the OR of all the stores' byte enables. Where two stores write the same byte, the later store's value is the one written.
- R4: A store to a line other than the one being gathered sends the gathered line to memory before the new store's line. Memory writes appear in the order the lines were opened.
- R5: Once all 32 byte enables of the gathered line are set, the line goes to memory with no further store, read or drain.
- R6: While `drain` is held high, all pending data goes to memory. `empty` is 1 exactly when neither stage holds data.
- R7: A read (`rd_valid`) whose `rd_line` matches a line held in either stage gets `rd_stall`=1 and `mem_rd_valid`=0. This lasts until that line's memory write has been accepted. A read of any other line gets `mem_rd_valid`=1 and `rd_stall`=0 in the same cycle.
- R8: A store is refused (`wr_ready`=0) only when both of these hold:
  - the outgoing stage holds a line that memory is not accepting this cycle;
  - the store needs the gathering stage to be emptied.
  While memory stalls, a store to the line being gathered is still taken.
- R9: While `mem_wr_valid` is 1 and `mem_wr_ready` is 0, `mem_wr_valid` stays 1 and the address, data and mask stay unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Store request |
| wr_addr | input | ADDR_W-2 (30) | Store word address |
| wr_data | input | 32 | Store data, little-endian byte lanes |
| wr_be | input | 4 | Store byte enables |
| wr_ready | output | 1 | Store taken this cycle when high |
| rd_valid | input | 1 | Read request |
| rd_line | input | ADDR_W-5 (27) | Line address of the read |
| rd_stall | output | 1 | Read must wait |
| mem_rd_valid | output | 1 | Read may go to memory now |
| drain | input | 1 | Hold high to push all pending data out |
| empty | output | 1 | No data pending |
| mem_wr_valid | output | 1 | Wide write request |
| mem_wr_ready | input | 1 | Memory accepts the wide write |
| mem_wr_addr | output | ADDR_W-5 (27) | Line address of the wide write |
| mem_wr_data | output | 256 | Line data |
| mem_wr_be | output | 32 | Per-byte write enables |

## Verification
The bench builds the block with its default sizes: 32-bit addresses, 32-bit words and 256-bit lines. With eight words per line, a short sequential spill fills a line and sets off the automatic flush. A line image of 256 bits is small enough to compare byte by byte against a line model kept in the bench. A memory-ready pattern that accepts one cycle in three, plus a phase where ready is held low, keeps the outgoing stage occupied. That exposes the refused-store case, merging while memory stalls, and read stalls against both stages.

// File: rtl/wcb_pkg.sv
// Shared constants and types for the write-combining line buffer.
package wcb_pkg;
    localparam int BYTE_W = 8;

    // Reason the gathering stage is being emptied this cycle.
    typedef enum logic [1:0] {
        FL_NONE  = 2'd0,
        FL_MISS  = 2'd1,
        FL_FULL  = 2'd2,
        FL_FORCE = 2'd3
    } flush_cause_e;
endpackage

// File: rtl/wcb_lane_merge.sv
// Places one word store into a line image.
// Builds the next line data and byte mask from a base line, either kept or
// discarded, and one word store with byte enables.
// Assumes: LINE_W is a power-of-two multiple of WORD_W, and WORD_W is a
// multiple of the byte width.
module wcb_lane_merge
    import wcb_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LINE_W = 256,
    localparam int WB     = WORD_W / BYTE_W,
    localparam int WPL    = LINE_W / WORD_W,
    localparam int WS_W   = $clog2(WPL),
    localparam int MASK_W = LINE_W / BYTE_W
) (
    input  logic [LINE_W-1:0] base_data,
    input  logic [MASK_W-1:0] base_mask,
    input  logic              keep_base,
    input  logic [WS_W-1:0]   word_sel,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WB-1:0]     wbe,
    output logic [LINE_W-1:0] new_data,
    output logic [MASK_W-1:0] new_mask
);
    for (genvar w = 0; w < WPL; w++) begin : g_word
        for (genvar j = 0; j < WB; j++) begin : g_byte
            localparam int IDX = w * WB + j;
            logic hit;
            // Select incoming byte, retained byte or zero for this lane.
            always_comb begin
                hit = wbe[j] && (word_sel == WS_W'(w));
                if (hit)
                    new_data[IDX*BYTE_W +: BYTE_W] = wdata[j*BYTE_W +: BYTE_W];
                else if (keep_base)
                    new_data[IDX*BYTE_W +: BYTE_W] = base_data[IDX*BYTE_W +: BYTE_W];
                else
                    new_data[IDX*BYTE_W +: BYTE_W] = '0;
                new_mask[IDX] = hit || (keep_base && base_mask[IDX]);
            end
        end
    end
endmodule

// File: rtl/wcb_line_stage.sv
// One line-wide holding stage: valid flag, line tag, data and byte mask.
// If load and clear are high together, load wins.
// Assumes: the caller drives clear only while the stage is valid.
module wcb_line_stage #(
    parameter int TAG_W  = 27,
    parameter int LINE_W = 256,
    localparam int MASK_W = LINE_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              clear,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [LINE_W-1:0] in_data,
    input  logic [MASK_W-1:0] in_mask,
    output logic              st_v,
    output logic [TAG_W-1:0]  st_tag,
    output logic [LINE_W-1:0] st_data,
    output logic [MASK_W-1:0] st_mask
);
    // Capture a new line, or release the held one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_v    <= 1'b0;
            st_tag  <= '0;
            st_data <= '0;
            st_mask <= '0;
        end else if (load) begin
            st_v    <= 1'b1;
            st_tag  <= in_tag;
            st_data <= in_data;
            st_mask <= in_mask;
        end else if (clear) begin
            st_v    <= 1'b0;
            st_mask <= '0;
        end
    end
endmodule

// File: rtl/wcb_flush_ctrl.sv
// Decision logic for the line buffer.
// It decides, each cycle:
//   - when the gathering stage moves into the outgoing stage;
//   - whether a store is taken, and whether it merges into the gathered line;
//   - whether a read must stall against a held line.
// Assumes: reads and stores are not presented in the same cycle.
module wcb_flush_ctrl
    import wcb_pkg::*;
#(
    parameter int TAG_W = 27
) (
    input  logic             act_v,
    input  logic             act_full,
    input  logic [TAG_W-1:0] act_tag,
    input  logic             out_v,
    input  logic [TAG_W-1:0] out_tag,
    input  logic             mem_wr_ready,
    input  logic             wr_valid,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             rd_valid,
    input  logic [TAG_W-1:0] rd_tag,
    input  logic             drain,
    output logic             move_now,
    output logic             wr_ready,
    output logic             wr_accept,
    output logic             keep_base,
    output logic             rd_stall
);
    flush_cause_e cause;
    logic same_line, rd_hit_act, rd_hit_out, out_free;

    // Classify the request against both stages.
    always_comb begin
        same_line  = act_v && (wr_tag == act_tag);
        rd_hit_act = rd_valid && act_v && (rd_tag == act_tag);
        rd_hit_out = rd_valid && out_v && (rd_tag == out_tag);
    end

    // Pick the reason (if any) to empty the gathering stage.
    always_comb begin
        if (!act_v)                   cause = FL_NONE;
        else if (act_full)            cause = FL_FULL;
        else if (drain || rd_hit_act) cause = FL_FORCE;
        else if (wr_valid && !same_line) cause = FL_MISS;
        else                          cause = FL_NONE;
    end

    // Move, accept and stall decisions.
    always_comb begin
        out_free  = !out_v || mem_wr_ready;
        move_now  = (cause != FL_NONE) && out_free;
        wr_ready  = !act_v || move_now || (same_line && !act_full);
        wr_accept = wr_valid && wr_ready;
        keep_base = same_line && !move_now;
        rd_stall  = rd_hit_act || rd_hit_out;
    end
endmodule

// File: rtl/wr_combine_buf.sv
// Write-combining posted line buffer (top).
// Gathers 32-bit byte-enabled stores into 256-bit masked line writes.
// A gathering stage collects stores; an outgoing stage holds one finished
// line for memory. Reads that hit a held line are stalled until it is written.
// Assumes: at most one of rd_valid / wr_valid per cycle, and drain is held
// until empty rises.
module wr_combine_buf
    import wcb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int LINE_W = 256,
    localparam int WB     = WORD_W / BYTE_W,
    localparam int MASK_W = LINE_W / BYTE_W,
    localparam int WPL    = LINE_W / WORD_W,
    localparam int WS_W   = $clog2(WPL),
    localparam int BS_W   = $clog2(WB),
    localparam int OFS_W  = $clog2(MASK_W),
    localparam int TAG_W  = ADDR_W - OFS_W,
    localparam int WA_W   = ADDR_W - BS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [WA_W-1:0]   wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [WB-1:0]     wr_be,
    output logic              wr_ready,
    input  logic              rd_valid,
    input  logic [TAG_W-1:0]  rd_line,
    output logic              rd_stall,
    output logic              mem_rd_valid,
    input  logic              drain,
    output logic              empty,
    output logic              mem_wr_valid,
    input  logic              mem_wr_ready,
    output logic [TAG_W-1:0]  mem_wr_addr,
    output logic [LINE_W-1:0] mem_wr_data,
    output logic [MASK_W-1:0] mem_wr_be
);
    logic [TAG_W-1:0]  wr_tag;
    logic [WS_W-1:0]   wr_word;
    logic              act_v, out_v;
    logic [TAG_W-1:0]  act_tag, out_tag;
    logic [LINE_W-1:0] act_data, out_data, mrg_data;
    logic [MASK_W-1:0] act_mask, out_mask, mrg_mask;
    logic              move_now, wr_accept, keep_base;

    // Split the store word address into line tag and word slot.
    always_comb begin
        wr_tag  = wr_addr[WA_W-1:WS_W];
        wr_word = wr_addr[WS_W-1:0];
    end

    wcb_flush_ctrl #(.TAG_W(TAG_W)) u_ctrl (
        .act_v       (act_v),
        .act_full    (&act_mask),
        .act_tag     (act_tag),
        .out_v       (out_v),
        .out_tag     (out_tag),
        .mem_wr_ready(mem_wr_ready),
        .wr_valid    (wr_valid),
        .wr_tag      (wr_tag),
        .rd_valid    (rd_valid),
        .rd_tag      (rd_line),
        .drain       (drain),
        .move_now    (move_now),
        .wr_ready    (wr_ready),
        .wr_accept   (wr_accept),
        .keep_base   (keep_base),
        .rd_stall    (rd_stall)
    );

    wcb_lane_merge #(.WORD_W(WORD_W), .LINE_W(LINE_W)) u_merge (
        .base_data(act_data),
        .base_mask(act_mask),
        .keep_base(keep_base),
        .word_sel (wr_word),
        .wdata    (wr_data),
        .wbe      (wr_be),
        .new_data (mrg_data),
        .new_mask (mrg_mask)
    );

    wcb_line_stage #(.TAG_W(TAG_W), .LINE_W(LINE_W)) u_gather (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (wr_accept),
        .clear  (move_now),
        .in_tag (wr_tag),
        .in_data(mrg_data),
        .in_mask(mrg_mask),
        .st_v   (act_v),
        .st_tag (act_tag),
        .st_data(act_data),
        .st_mask(act_mask)
    );

    wcb_line_stage #(.TAG_W(TAG_W), .LINE_W(LINE_W)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (move_now),
        .clear  (out_v && mem_wr_ready),
        .in_tag (act_tag),
        .in_data(act_data),
        .in_mask(act_mask),
        .st_v   (out_v),
        .st_tag (out_tag),
        .st_data(out_data),
        .st_mask(out_mask)
    );

    // Drive the memory-side and status outputs.
    always_comb begin
        mem_wr_valid = out_v;
        mem_wr_addr  = out_tag;
        mem_wr_data  = out_data;
        mem_wr_be    = out_mask;
        empty        = !act_v && !out_v;
        mem_rd_valid = rd_valid && !rd_stall;
    end
endmodule

// File: rtl/wcb_checker.sv
// Port-level properties of the write-combining buffer, bound to the top.
module wcb_checker #(
    parameter int TAG_W  = 27,
    parameter int LINE_W = 256,
    localparam int MASK_W = LINE_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic              rd_stall,
    input logic              empty,
    input logic              mem_wr_valid,
    input logic              mem_wr_ready,
    input logic [TAG_W-1:0]  mem_wr_addr,
    input logic [LINE_W-1:0] mem_wr_data,
    input logic [MASK_W-1:0] mem_wr_be
);
    // R9: an unaccepted wide write holds steady.
    p_hold_payload_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_ready) |=> (mem_wr_valid && $stable(mem_wr_addr)
            && $stable(mem_wr_data) && $stable(mem_wr_be)));

    // R6: nothing goes to memory while the buffer reports empty.
    p_empty_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !mem_wr_valid);

    // R8: with the outgoing stage free, a store is never refused.
    p_free_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !mem_wr_valid) |-> wr_ready);

    // R3: every wide write carries at least one enabled byte.
    p_mask_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> (|mem_wr_be));

    // R7: a stalled read implies data is pending.
    p_stall_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stall |-> !empty);
endmodule

bind wr_combine_buf wcb_checker #(.TAG_W(TAG_W), .LINE_W(LINE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .rd_stall    (rd_stall),
    .empty       (empty),
    .mem_wr_valid(mem_wr_valid),
    .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr (mem_wr_addr),
    .mem_wr_data (mem_wr_data),
    .mem_wr_be   (mem_wr_be)
);

// File: tb/tb_wr_combine_buf.sv
// Scoreboard bench: store tasks keep a line model and queue the expected
// wide writes, and a monitor compares each accepted memory write.
module tb_wr_combine_buf;
    localparam int ADDR_W = 32;

    typedef struct {
        logic [26:0]  addr;
        logic [255:0] data;
        logic [31:0]  be;
    } line_t;

    logic         clk = 0, rst_n = 0;
    logic         wr_valid = 0, rd_valid = 0, drain = 0, mem_wr_ready = 1;
    logic [29:0]  wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic [3:0]   wr_be = '0;
    logic [26:0]  rd_line = '0;
    logic         wr_ready, rd_stall, mem_rd_valid, empty, mem_wr_valid;
    logic [26:0]  mem_wr_addr;
    logic [255:0] mem_wr_data;
    logic [31:0]  mem_wr_be;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit hold_rdy = 0, bp = 0, done = 0;
    line_t exp_q[$];
    bit m_v = 0;
    logic [26:0]  m_tag = '0;
    logic [255:0] m_data = '0;
    logic [31:0]  m_mask = '0;

    wr_combine_buf #(.ADDR_W(ADDR_W)) dut (.*);

    always #10 clk = ~clk;

    // Memory ready pattern, changed shortly after each rising edge.
    always @(posedge clk) begin
        cyc++;
        #2;
        mem_wr_ready = hold_rdy ? 1'b0 : (bp ? (cyc % 3 == 0) : 1'b1);
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic push_model();
        line_t it;
        it.addr = m_tag; it.data = m_data; it.be = m_mask;
        exp_q.push_back(it);
        m_v = 0; m_data = '0; m_mask = '0;
    endtask

    // Monitor: compare each accepted wide write with the scoreboard.
    always @(negedge clk) begin
        if (rst_n && mem_wr_valid && mem_wr_ready) begin
            if (exp_q.size() == 0) begin
                check(0, "R4", "unexpected wide write", 256'(mem_wr_addr), 0);
            end else begin
                line_t e;
                logic [255:0] bm;
                e = exp_q.pop_front();
                for (int k = 0; k < 32; k++) bm[8*k +: 8] = {8{e.be[k]}};
                check(mem_wr_addr == e.addr, "R2", "line address", 256'(mem_wr_addr), 256'(e.addr));
                check(mem_wr_be == e.be, "R3", "byte mask", 256'(mem_wr_be), 256'(e.be));
                check((mem_wr_data & bm) == (e.data & bm), "R3", "merged data",
                      mem_wr_data & bm, e.data & bm);
            end
        end
    end

    // Store one word; updates the model and waits for acceptance.
    task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be,
                      output bit first_ready);
        logic [26:0] tg;
        tg = a[31:5];
        if (m_v && tg != m_tag) push_model();
        for (int j = 0; j < 4; j++)
            if (be[j]) begin
                m_data[8*(4*a[4:2]+j) +: 8] = d[8*j +: 8];
                m_mask[4*a[4:2]+j] = 1'b1;
            end
        m_v = 1; m_tag = tg;
        @(negedge clk);
        wr_valid = 1; wr_addr = a[31:2]; wr_data = d; wr_be = be;
        #1;
        first_ready = wr_ready;
        while (!wr_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        wr_valid = 0;
        if (&m_mask) push_model();
    endtask

    task automatic wrs(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
        bit fr;
        wr(a, d, be, fr);
    endtask

    // Read a line; a hit must stall until its line has reached memory.
    task automatic rd(input logic [26:0] ln, input bit hit);
        if (m_v && m_tag == ln) push_model();
        @(negedge clk);
        rd_valid = 1; rd_line = ln;
        #1;
        if (hit) begin
            check(rd_stall && !mem_rd_valid, "R7", "hit read stalled",
                  {rd_stall, mem_rd_valid}, 2'b10);
            while (rd_stall) begin @(negedge clk); #1; end
            check(exp_q.size() == 0, "R7", "line written before read released",
                  exp_q.size(), 0);
        end
        check(mem_rd_valid && !rd_stall, "R7", "read goes to memory",
              {rd_stall, mem_rd_valid}, 2'b01);
        @(posedge clk); #1;
        rd_valid = 0;
    endtask

    task automatic drn();
        if (m_v) push_model();
        @(negedge clk);
        drain = 1;
        #1;
        while (!empty) begin @(negedge clk); #1; end
        check(empty && exp_q.size() == 0, "R6", "empty after drain", {empty, 1'b0}, 2'b10);
        drain = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : stim
        bit fr;
        repeat (3) @(negedge clk);
        check(empty && !mem_wr_valid && wr_ready, "R1", "reset state",
              {empty, mem_wr_valid, wr_ready}, 3'b101);
        rst_n = 1;
        @(negedge clk);
        check(empty && !mem_wr_valid && wr_ready, "R1", "after reset",
              {empty, mem_wr_valid, wr_ready}, 3'b101);

        // R5: eight sequential full-word stores fill and flush a line.
        for (int i = 0; i < 8; i++) wrs(32'h1000 + 4*i, 32'hA000_0000 + i, 4'hF);
        repeat (6) @(negedge clk);
        check(empty && exp_q.size() == 0, "R5", "full line flushed by itself",
              {empty, 1'b0}, 2'b10);

        // R2 / R3: sub-word merges and a byte overwrite.
        wrs(32'h2004, 32'h0000_0011, 4'b0001);
        wrs(32'h2004, 32'h0033_0000, 4'b0100);
        wrs(32'h2004, 32'h0000_0055, 4'b0001);
        wrs(32'h201C, 32'h7700_0000, 4'b1000);
        @(negedge clk);
        check(!empty, "R6", "empty low while data pending", empty, 0);
        drn();

        // R4: store to another line pushes the earlier one first.
        wrs(32'h3000, 32'h1111_1111, 4'hF);
        wrs(32'h3040, 32'h2222_2222, 4'hF);
        wrs(32'h3044, 32'h3333_3333, 4'b0011);
        drn();

        // R7: read hit on the gathered line, then a miss.
        wrs(32'h4008, 32'hDEAD_BEEF, 4'hF);
        rd(27'h200, 1);
        rd(27'h280, 0);

        // R8 / R9 / R7: memory held off with the outgoing stage full.
        hold_rdy = 1;
        @(posedge clk); #3;
        wrs(32'h6000, 32'h6000_0001, 4'hF);
        wrs(32'h6020, 32'h6020_0002, 4'hF);
        @(negedge clk); #1;
        check(mem_wr_valid && mem_wr_addr == 27'h300, "R9", "outgoing line presented",
              256'(mem_wr_addr), 256'h300);
        wr(32'h6024, 32'h6024_0003, 4'hF, fr);
        check(fr, "R8", "same-line store taken while memory stalls", fr, 1);
        @(negedge clk);
        wr_valid = 1; wr_addr = 30'h6040 >> 2; wr_data = 32'h5; wr_be = 4'hF;
        for (int k = 0; k < 3; k++) begin
            #1;
            check(!wr_ready, "R8", "new-line store refused while stalled", wr_ready, 0);
            check(mem_wr_valid && mem_wr_addr == 27'h300, "R9", "payload held",
                  256'(mem_wr_addr), 256'h300);
            @(negedge clk);
        end
        wr_valid = 0;
        rd_valid = 1; rd_line = 27'h300;
        #1;
        check(rd_stall && !mem_rd_valid, "R7", "read stalls on outgoing line",
              {rd_stall, mem_rd_valid}, 2'b10);
        @(negedge clk);
        rd_valid = 0;
        hold_rdy = 0;
        wrs(32'h6040, 32'h6040_0004, 4'hF);
        drn();

        // R3 / R9: spill over two lines with slow memory acceptance.
        bp = 1;
        for (int i = 0; i < 16; i++)
            wrs(32'h7000 + 4*i, 32'h7000_0000 ^ (i * 32'h0101_0101),
                (i % 3 == 0) ? 4'b0110 : 4'hF);
        drn();
        bp = 0;

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0 && empty, "R4", "all lines delivered in order",
              exp_q.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule